// File: doc/BRIEF.md
# Credit-Based Link Flow Controller

This block joins the sending and receiving ends of one point-to-point link between two switches. Tokens arrive at the transmit end on a valid/ready stream. Each token is either a plain data token or a user control token. They cross a modelled channel that holds each token for a fixed number of cycles. They land in a small receive buffer and leave on a second valid/ready stream. The link carries two more token kinds for its own use: a greeting that the transmitter sends when the link is switched on, and a credit token that the receiver sends back.

The transmitter keeps a credit counter. A user token can only be accepted while that counter is non-zero, and each accepted token lowers the counter by one. When the link enable rises, the transmitter sends one greeting and waits. The receiver answers with a credit token that grants every free buffer entry, and data may flow only after that grant arrives. After that, the receiver counts the entries the consumer drains. Once the count reaches a batch threshold, the receiver returns all of it in one credit token. A full buffer therefore stops the transmit stream, and the buffer can never overrun. Greeting and credit tokens are never written into the buffer.

Top module: `credlink_top`

## Requirements
- R1: While link_en is low, and after enable until the first credit grant reaches the transmitter, in_ready is low.
- R2: On a rising link_en the transmitter sends exactly one greeting token and no data. Because the greeting and its answer each cross the channel, in_ready stays low for at least 2*DELAY cycles after enable.
- R3: The receive buffer never overruns. With the consumer stalled, at most DEPTH user tokens are accepted, and after that in_ready stays low.
- R4: The receiver answers a greeting with one credit token whose value is the number of free buffer entries, which is DEPTH for an empty buffer.
- R5: Credit returns are batched. Draining fewer than THRESH entries returns no credit. Draining the THRESH-th entry returns credit for exactly THRESH more tokens.
- R6: Greeting and credit tokens take no buffer entry and never appear on the output stream: out_valid stays low during link bring-up.
- R7: User tokens leave in the order they were accepted, with in_data and in_ctl unchanged (in_ctl=1 marks a user control token).
- R8: With an empty buffer, out_valid rises on the DELAY-th rising clock edge after the edge that accepted the token.
- R9: Dropping link_en clears the transmitter's credit. Raising it again repeats the greeting exchange and yields a fresh full grant of DEPTH tokens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_en | input | 1 | Link enable; a rising edge starts the greeting exchange |
| in_valid | input | 1 | Transmit stream token valid |
| in_ready | output | 1 | Transmit stream ready; high only while credit is held |
| in_data | input | DW | Transmit token payload |
| in_ctl | input | 1 | 1 = user control token, 0 = data token |
| out_valid | output | 1 | Receive stream token valid |
| out_ready | input | 1 | Receive stream consumer ready |
| out_data | output | DW | Received token payload |
| out_ctl | output | 1 | Received token control flag |

## Verification
The bench builds the block with DEPTH=4, THRESH=2 and DELAY=3. A four-entry buffer fills in a few cycles, so stalling the consumer shows the exact credit grant and the point where in_ready drops. A threshold of two allows a single-entry drain that must return nothing to be told apart from a second drain that must release exactly two tokens. A three-cycle channel makes the bring-up delay and the per-token latency long enough to count exactly. The bench also checks that a disable and re-enable restores the full grant.

// File: rtl/credlink_pkg.sv
package credlink_pkg;

  typedef enum logic [1:0] {
    TK_DATA   = 2'd0,
    TK_USER   = 2'd1,
    TK_HELLO  = 2'd2,
    TK_CREDIT = 2'd3
  } tok_kind_e;

  typedef enum logic [1:0] {
    TX_OFF   = 2'd0,
    TX_HELLO = 2'd1,
    TX_WAIT  = 2'd2,
    TX_RUN   = 2'd3
  } tx_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/credlink_chan.sv
module credlink_chan #(
  parameter int W     = 10,
  parameter int DELAY = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_tok,
  output logic         out_vld,
  output logic [W-1:0] out_tok
);

  generate
    if (DELAY == 0) begin : g_wire
      assign out_vld = in_vld;
      assign out_tok = in_tok;
    end else begin : g_pipe
      logic [DELAY-1:0] vld_q;
      logic [DELAY-1:0] vld_d;
      logic [W-1:0]     tok_q [DELAY];

      always_comb begin
        vld_d[0] = in_vld;
        for (int i = 1; i < DELAY; i++) begin
          vld_d[i] = vld_q[i-1];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        if (in_vld) tok_q[0] <= in_tok;
        for (int i = 1; i < DELAY; i++) begin
          if (vld_q[i-1]) tok_q[i] <= tok_q[i-1];
        end
      end

      assign out_vld = vld_q[DELAY-1];
      assign out_tok = tok_q[DELAY-1];
    end
  endgenerate

endmodule

// File: rtl/credlink_fifo.sv
module credlink_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  push_tok,
  input  logic          pop,
  output logic [W-1:0]  head_tok,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    wr_d  = push ? bump(wr_q) : wr_q;
    rd_d  = pop  ? bump(rd_q) : rd_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_tok;
  end

  assign head_tok = mem[rd_q];
  assign empty    = (cnt_q == '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign count    = cnt_q;

  // R3: occupancy never exceeds the buffer size
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7: a read never happens on an empty buffer
  a_r7_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

endmodule

// File: rtl/credlink_tx.sv
module credlink_tx
  import credlink_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int PW    = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_ctl,
  output logic          fwd_vld,
  output tok_kind_e     fwd_kind,
  output logic [PW-1:0] fwd_pay,
  input  logic          rev_vld,
  input  tok_kind_e     rev_kind,
  input  logic [PW-1:0] rev_pay
);

  tx_state_e     state_q, state_d;
  logic [CW-1:0] credit_q, credit_d;
  logic [CW-1:0] credit_add;
  logic          credit_hit;
  logic          send;

  always_comb begin
    credit_hit = rev_vld && (rev_kind == TK_CREDIT) &&
                 ((state_q == TX_WAIT) || (state_q == TX_RUN));
    credit_add = credit_hit ? rev_pay[CW-1:0] : '0;
    in_ready   = link_en && (state_q == TX_RUN) && (credit_q != '0);
    send       = in_valid && in_ready;

    fwd_vld    = send || (link_en && (state_q == TX_HELLO));
    fwd_kind   = (state_q == TX_HELLO) ? TK_HELLO : (in_ctl ? TK_USER : TK_DATA);
    fwd_pay    = '0;
    fwd_pay[DW-1:0] = in_data;
  end

  always_comb begin
    state_d = state_q;
    if (!link_en) begin
      state_d = TX_OFF;
    end else begin
      case (state_q)
        TX_OFF:   state_d = TX_HELLO;
        TX_HELLO: state_d = TX_WAIT;
        TX_WAIT:  if (credit_hit) state_d = TX_RUN;
        TX_RUN:   state_d = TX_RUN;
        default:  state_d = TX_OFF;
      endcase
    end
  end

  always_comb begin
    if (!link_en) credit_d = '0;
    else          credit_d = credit_q - CW'(send) + credit_add;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= TX_OFF;
      credit_q <= '0;
    end else begin
      state_q  <= state_d;
      credit_q <= credit_d;
    end
  end

  // R2: a rising enable is followed by a greeting on the link
  a_r2_hello_on_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_en) |=> (fwd_vld && (fwd_kind == TK_HELLO)));

  // R3: credit held never exceeds the remote buffer size
  a_r3_credit_cap: assert property (@(posedge clk) disable iff (!rst_n)
    credit_q <= CW'(DEPTH));

  // R4: a grant received while waiting opens the link with credit
  a_r4_grant_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (link_en && (state_q == TX_WAIT) && credit_hit && (credit_add != '0))
      |=> ((state_q == TX_RUN) && (credit_q != '0)));

endmodule

// File: rtl/credlink_rx.sv
module credlink_rx
  import credlink_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 8,
  parameter int THRESH = 2,
  parameter int PW     = 8,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_vld,
  input  tok_kind_e     fwd_kind,
  input  logic [PW-1:0] fwd_pay,
  output logic          rev_vld,
  output tok_kind_e     rev_kind,
  output logic [PW-1:0] rev_pay,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_ctl
);

  logic          push, pop, hello_in, batch_go;
  logic          empty, full;
  logic [CW-1:0] count;
  logic [DW:0]   head;
  logic [DW:0]   push_tok;
  logic [CW-1:0] pend_q, pend_d;

  always_comb begin
    push     = fwd_vld && ((fwd_kind == TK_DATA) || (fwd_kind == TK_USER));
    push_tok = {(fwd_kind == TK_USER), fwd_pay[DW-1:0]};
    hello_in = fwd_vld && (fwd_kind == TK_HELLO);
    pop      = out_valid && out_ready;
  end

  credlink_fifo #(.W(DW + 1), .DEPTH(DEPTH)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_tok (push_tok),
    .pop      (pop),
    .head_tok (head),
    .empty    (empty),
    .full     (full),
    .count    (count)
  );

  assign out_valid = !empty;
  assign out_data  = head[DW-1:0];
  assign out_ctl   = head[DW];

  always_comb begin
    batch_go = !hello_in && (pend_q >= CW'(THRESH));
    rev_vld  = hello_in || batch_go;
    rev_kind = TK_CREDIT;
    rev_pay  = '0;
    if (hello_in) rev_pay[CW-1:0] = CW'(DEPTH) - count;
    else          rev_pay[CW-1:0] = pend_q;

    if (hello_in || batch_go) pend_d = CW'(pop);
    else                      pend_d = pend_q + CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  // R3: a token never arrives at a full buffer
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R5: freed entries waiting for return stay within the buffer size
  a_r5_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= CW'(DEPTH));

  // R6: a greeting leaves the buffer occupancy untouched apart from a drain
  a_r6_hello_not_stored: assert property (@(posedge clk) disable iff (!rst_n)
    (hello_in && !pop) |=> (count == $past(count)));

endmodule

// File: rtl/credlink_top.sv
module credlink_top
  import credlink_pkg::*;
#(
  parameter int DW     = 8,
  parameter int DEPTH  = 8,
  parameter int DELAY  = 3,
  parameter int THRESH = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_en,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_ctl,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_ctl
);

  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = imax(DW, CW);
  localparam int TW = 2 + PW;

  logic          tx_vld, rx_vld, cr_vld, cr_in_vld;
  tok_kind_e     tx_kind, rx_kind, cr_kind, cr_in_kind;
  logic [PW-1:0] tx_pay, rx_pay, cr_pay, cr_in_pay;
  logic [TW-1:0] fwd_in_tok, fwd_out_tok, rev_in_tok, rev_out_tok;

  credlink_tx #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_en  (link_en),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_ctl   (in_ctl),
    .fwd_vld  (tx_vld),
    .fwd_kind (tx_kind),
    .fwd_pay  (tx_pay),
    .rev_vld  (cr_in_vld),
    .rev_kind (cr_in_kind),
    .rev_pay  (cr_in_pay)
  );

  assign fwd_in_tok = {tx_kind, tx_pay};

  credlink_chan #(.W(TW), .DELAY(DELAY)) u_fwd (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (tx_vld),
    .in_tok  (fwd_in_tok),
    .out_vld (rx_vld),
    .out_tok (fwd_out_tok)
  );

  assign rx_kind = tok_kind_e'(fwd_out_tok[TW-1 -: 2]);
  assign rx_pay  = fwd_out_tok[PW-1:0];

  credlink_rx #(.DW(DW), .DEPTH(DEPTH), .THRESH(THRESH), .PW(PW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_vld   (rx_vld),
    .fwd_kind  (rx_kind),
    .fwd_pay   (rx_pay),
    .rev_vld   (cr_vld),
    .rev_kind  (cr_kind),
    .rev_pay   (cr_pay),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ctl   (out_ctl)
  );

  assign rev_in_tok = {cr_kind, cr_pay};

  credlink_chan #(.W(TW), .DELAY(DELAY)) u_rev (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (cr_vld),
    .in_tok  (rev_in_tok),
    .out_vld (cr_in_vld),
    .out_tok (rev_out_tok)
  );

  assign cr_in_kind = tok_kind_e'(rev_out_tok[TW-1 -: 2]);
  assign cr_in_pay  = rev_out_tok[PW-1:0];

  // R1: the transmit stream is closed while the link is disabled
  a_r1_closed_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_en) |=> !(tx_vld && (tx_kind != TK_HELLO)) || link_en);

endmodule

// File: tb/sim_credlink_top.sv
`timescale 1ns/1ps
module sim_credlink_top;

  localparam int DW     = 8;
  localparam int DEPTH  = 4;
  localparam int DELAY  = 3;
  localparam int THRESH = 2;

  logic          clk;
  logic          rst_n;
  logic          link_en;
  logic          in_valid;
  logic          in_ready;
  logic [DW-1:0] in_data;
  logic          in_ctl;
  logic          out_valid;
  logic          out_ready;
  logic [DW-1:0] out_data;
  logic          out_ctl;

  int checks = 0;
  int errors = 0;
  int n_acc  = 0;
  int n_rcv  = 0;
  int wr_i   = 0;
  int rd_i   = 0;
  logic          ov_seen;
  logic          acc_seen;
  logic [DW:0]   exp_mem [0:1023];

  credlink_top #(.DW(DW), .DEPTH(DEPTH), .DELAY(DELAY), .THRESH(THRESH)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_en   (link_en),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .in_ctl    (in_ctl),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_ctl   (out_ctl)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one cycle: observe at negedge, advance stimulus just after posedge
  task automatic step();
    @(negedge clk);
    acc_seen = in_valid && in_ready;
    ov_seen  = out_valid;
    if (acc_seen) begin
      exp_mem[wr_i % 1024] = {in_ctl, in_data};
      wr_i++;
      n_acc++;
    end
    if (out_valid && out_ready) begin
      chk({out_ctl, out_data} == exp_mem[rd_i % 1024], "R7 order/payload",
          int'({out_ctl, out_data}), int'(exp_mem[rd_i % 1024]));
      rd_i++;
      n_rcv++;
    end
    @(posedge clk);
    #1;
    if (acc_seen) begin
      in_data = in_data + 8'd29;
      in_ctl  = in_data[1];
    end
  endtask

  task automatic t_reset();
    step();
    chk(in_ready == 1'b0, "R1 in_ready after reset", int'(in_ready), 0);
    chk(out_valid == 1'b0, "R6 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_linkup();
    int  k = 0;
    logic ov_any = 1'b0;
    link_en = 1'b1;
    while (!in_ready && k < 40) begin
      step();
      k++;
      if (ov_seen) ov_any = 1'b1;
    end
    chk(k >= 2*DELAY, "R2 bring-up cycles", k, 2*DELAY);
    chk(k < 40, "R4 grant arrives", k, 2*DELAY + 2);
    chk(!ov_any, "R6 no output during bring-up", int'(ov_any), 0);
  endtask

  task automatic t_fill();
    int n0 = n_acc;
    out_ready = 1'b0;
    in_valid  = 1'b1;
    repeat (30) step();
    chk(n_acc - n0 == DEPTH, "R4 initial grant size", n_acc - n0, DEPTH);
    chk(in_ready == 1'b0, "R3 stalled when full", int'(in_ready), 0);
    repeat (20) step();
    chk(n_acc - n0 == DEPTH, "R3 no overrun", n_acc - n0, DEPTH);
  endtask

  task automatic t_batch();
    int n0;
    repeat (THRESH - 1) begin
      out_ready = 1'b1; step(); out_ready = 1'b0;
    end
    n0 = n_acc;
    repeat (20) step();
    chk(n_acc - n0 == 0, "R5 below threshold returns nothing", n_acc - n0, 0);
    out_ready = 1'b1; step(); out_ready = 1'b0;
    n0 = n_acc;
    repeat (20) step();
    chk(n_acc - n0 == THRESH, "R5 batch credit", n_acc - n0, THRESH);
  endtask

  task automatic t_drain();
    out_ready = 1'b1;
    in_valid  = 1'b1;
    repeat (40) step();
    in_valid = 1'b0;
    repeat (30) step();
    chk(n_rcv == n_acc, "R7 all tokens delivered", n_rcv, n_acc);
    chk(out_valid == 1'b0, "R7 buffer empty", int'(out_valid), 0);
  endtask

  task automatic t_latency();
    int k = 0;
    int w = 0;
    out_ready = 1'b1;
    in_valid  = 1'b1;
    acc_seen  = 1'b0;
    while (!acc_seen && w < 30) begin
      step();
      w++;
    end
    in_valid = 1'b0;
    ov_seen  = 1'b0;
    while (!ov_seen && k < 30) begin
      step();
      k++;
    end
    // negedge k=1 follows the accepting edge; out_valid after DELAY edges
    chk(k == DELAY + 1, "R8 token latency", k, DELAY + 1);
    repeat (10) step();
  endtask

  task automatic t_reenable();
    int n0;
    out_ready = 1'b1;
    in_valid  = 1'b0;
    repeat (20) step();
    link_en = 1'b0;
    in_valid = 1'b1;
    step();
    chk(in_ready == 1'b0, "R1 closed while disabled", int'(in_ready), 0);
    n0 = n_acc;
    repeat (2*DELAY + 4) step();
    chk(n_acc == n0, "R1 nothing accepted while disabled", n_acc - n0, 0);
    out_ready = 1'b0;
    link_en   = 1'b1;
    n0 = n_acc;
    repeat (40) step();
    chk(n_acc - n0 == DEPTH, "R9 fresh full grant", n_acc - n0, DEPTH);
    in_valid  = 1'b0;
    out_ready = 1'b1;
    repeat (30) step();
    chk(n_rcv == n_acc, "R9 delivered after re-enable", n_rcv, n_acc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    rst_n     = 1'b0;
    link_en   = 1'b0;
    in_valid  = 1'b0;
    in_data   = 8'h11;
    in_ctl    = 1'b0;
    out_ready = 1'b0;
    ov_seen   = 1'b0;
    acc_seen  = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    t_reset();
    t_linkup();
    t_fill();
    t_batch();
    t_drain();
    t_latency();
    t_reenable();
    summary();
  end

endmodule